// File: doc/BRIEF.md
# Dual-Source Write Synchronous FIFO

This block is a single-clock first-in first-out buffer. Its word width and its depth are parameters. Two write buses of equal width feed the block. On every push, a select input decides which of the two buses is stored. The oldest stored word is always visible on the read bus, so the read side is first-word-fall-through. A pop request removes that word.

The block reports its state through two level flags. `pop_ok` is high while at least one word is stored. `push_ok` is high while at least one slot is free. A producer may hold `push_req` high and let `push_ok` decide when a word is taken. A consumer may do the same with `pop_req` and `pop_ok`. Occupancy is kept in a counter that is one bit wider than the pointers. Both pointers wrap modulo the depth, so the depth does not have to be a power of two.

Top module: `dual_src_fifo`

## Requirements
- R1: `rst` is synchronous and active high. At the clock edge where it is sampled high, it clears both pointers and the occupancy count. This holds even when requests are asserted. In the following cycle `pop_ok` is 0 and `push_ok` is 1.
- R2: `pop_ok` is 1 exactly when at least one word is stored.
- R3: `push_ok` is 1 exactly when fewer than DEPTH words are stored.
- R4: An accepted push stores `din_a` when `bus_sel` is 0 and `din_b` when `bus_sel` is 1. The bus that is not selected is never stored.
- R5: A pop takes effect only when `pop_req` and `pop_ok` are both high. A pop request while the FIFO is empty is ignored: `pop_ok` stays 0 and no word is lost.
- R6: A push request while the FIFO is full and no pop is accepted is ignored. The FIFO stays full and `dout` keeps its value.
- R7: Whenever `pop_ok` is 1, `dout` shows the oldest stored word. It holds that value until a pop is accepted.
- R8: Words leave in the order they were accepted. This includes the point where the pointers wrap past DEPTH-1 back to 0.
- R9: When the FIFO is neither empty nor full, a push and a pop in the same cycle both take effect. The occupancy does not change.
- R10: When the FIFO is full, a push and a pop in the same cycle both take effect. The FIFO stays full, and the new word becomes the newest entry.
- R11: When the FIFO is empty, a push and a pop in the same cycle perform only the push. The new word appears on `dout` in the next cycle, and there is no same-cycle path from the write buses to `dout`.
- R12: WORD_W must be even and between 2 and 64. DEPTH must be even and between 4 and 32. Any other setting is reported at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pop_req | input | 1 | Request to remove the oldest word |
| push_req | input | 1 | Request to store a word from the selected bus |
| pop_ok | output | 1 | Level flag: FIFO holds at least one word |
| push_ok | output | 1 | Level flag: FIFO has a free slot |
| bus_sel | input | 1 | Write bus select: 0 picks `din_a`, 1 picks `din_b` |
| din_a | input | WORD_W | First write bus |
| din_b | input | WORD_W | Second write bus |
| dout | output | WORD_W | Oldest stored word (valid while `pop_ok` is 1) |

## Verification
Every push puts different values on the two write buses. A stored value therefore reveals which bus was taken, and a swapped or stuck select shows up as a wrong `dout`. The stimulus runs three kinds of traffic:
- a fill to full, a drain to empty, and the pointer wrap in between, which separates correct ordering from pointer or count slips;
- simultaneous push and pop at each occupancy class (empty, partial and full), which separates the three ways a collision can be resolved;
- requests held against a low flag, and reset asserted while requests are active, which show whether an ignored request or the reset leaks into state.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    // One cycle's accepted operations.
    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;

    // Occupancy class derived from the counter.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    // True when v is even and lies within [lo, hi].
    function automatic logic even_in_range(int v, int lo, int hi);
        return (v % 2 == 0) && (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/dsf_src_mux.sv
module dsf_src_mux #(
    parameter int WORD_W = 8
) (
    input  logic              pick_b,
    input  logic [WORD_W-1:0] bus_a,
    input  logic [WORD_W-1:0] bus_b,
    output logic [WORD_W-1:0] chosen
);
    assign chosen = pick_b ? bus_b : bus_a;
endmodule

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
    import dsf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output xfer_t            xfer,
    output logic             can_read,
    output logic             can_write
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [CNT_W-1:0] fill_q;
    occ_e             occ;

    always_comb begin
        if (fill_q == '0)
            occ = OCC_EMPTY;
        else if (fill_q == FULL_CNT)
            occ = OCC_FULL;
        else
            occ = OCC_PART;
    end

    assign can_read  = (occ != OCC_EMPTY);
    assign can_write = (occ != OCC_FULL);

    // A pop frees a slot in the same cycle, so a full FIFO may accept a push
    // alongside an accepted pop. An empty FIFO never pops.
    assign xfer.pop  = pop_req & can_read;
    assign xfer.push = push_req & (can_write | xfer.pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (xfer.push)
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            if (xfer.pop)
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            case ({xfer.push, xfer.pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end
endmodule

// File: rtl/dsf_store.sv
module dsf_store #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [DEPTH*WORD_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(g)))
                word_q <= wr_data;
        end
        assign flat[g*WORD_W +: WORD_W] = word_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == PTR_W'(i))
                rd_data = flat[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/dual_src_fifo.sv
module dual_src_fifo
    import dsf_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_req,
    input  logic              push_req,
    output logic              pop_ok,
    output logic              push_ok,
    input  logic              bus_sel,
    input  logic [WORD_W-1:0] din_a,
    input  logic [WORD_W-1:0] din_b,
    output logic [WORD_W-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [WORD_W-1:0] wr_word;
    xfer_t             xfer;

    dsf_src_mux #(.WORD_W(WORD_W)) u_mux (
        .pick_b (bus_sel),
        .bus_a  (din_a),
        .bus_b  (din_b),
        .chosen (wr_word)
    );

    dsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .xfer      (xfer),
        .can_read  (pop_ok),
        .can_write (push_ok)
    );

    dsf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (xfer.push),
        .wr_addr (wr_ptr),
        .wr_data (wr_word),
        .rd_addr (rd_ptr),
        .rd_data (dout)
    );
endmodule

// File: rtl/dsf_chk.sv
module dsf_chk
    import dsf_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pop_req,
    input logic              push_req,
    input logic              pop_ok,
    input logic              push_ok,
    input logic              bus_sel,
    input logic [WORD_W-1:0] din_a,
    input logic [WORD_W-1:0] din_b,
    input logic [WORD_W-1:0] dout
);
    initial begin
        AST_PARAM_RANGE: assert (even_in_range(WORD_W, 2, 64) && even_in_range(DEPTH, 4, 32))
            else $error("parameter out of range"); // R12
    end

    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pop_ok && push_ok)); // R1

    AST_PUSH_SETS_POP_OK: assert property (@(posedge clk) disable iff (rst)
        (push_req && push_ok && !(pop_req && pop_ok)) |=> pop_ok); // R2

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !push_ok |-> pop_ok); // R3

    AST_EMPTY_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!pop_ok && push_req) |=>
            (pop_ok && dout == ($past(bus_sel) ? $past(din_b) : $past(din_a)))); // R4

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!pop_ok && !push_req) |=> !pop_ok); // R5

    AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!push_ok && !pop_req) |=> (!push_ok && $stable(dout))); // R6

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !pop_req) |=> $stable(dout)); // R7

    AST_MID_BOTH: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && push_ok && push_req && pop_req) |=> (pop_ok && push_ok)); // R9

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (!push_ok && push_req && pop_req) |=> !push_ok); // R10

    AST_EMPTY_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (!pop_ok && push_req && pop_req) |=> (pop_ok && push_ok)); // R11
endmodule

bind dual_src_fifo dsf_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pop_req  (pop_req),
    .push_req (push_req),
    .pop_ok   (pop_ok),
    .push_ok  (push_ok),
    .bus_sel  (bus_sel),
    .din_a    (din_a),
    .din_b    (din_b),
    .dout     (dout)
);

// File: tb/sim_dual_src_fifo.sv
`timescale 1ns/1ps
module sim_dual_src_fifo;
    localparam int W = 8;
    localparam int D = 8;
    localparam int NV = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pop_req = 1'b0;
    logic         push_req = 1'b0;
    logic         bus_sel = 1'b0;
    logic [W-1:0] din_a = '0;
    logic [W-1:0] din_b = '0;
    logic         pop_ok;
    logic         push_ok;
    logic [W-1:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model
    logic [W-1:0] mq [D];
    int mh = 0, mt = 0, mc = 0;

    always #2.5 clk = ~clk;

    dual_src_fifo #(.WORD_W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .pop_req(pop_req), .push_req(push_req),
        .pop_ok(pop_ok), .push_ok(push_ok), .bus_sel(bus_sel),
        .din_a(din_a), .din_b(din_b), .dout(dout)
    );

    // {push, pop, sel, a, b, expected pop_ok, expected push_ok}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,8'h11,8'hE1,2'b11},
        {1'b1,1'b0,1'b1,8'hE2,8'h22,2'b11},
        {1'b1,1'b0,1'b0,8'h33,8'hE3,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b1,1'b1,1'b1,8'hE4,8'h44,2'b11},
        {1'b1,1'b0,1'b0,8'h55,8'hE5,2'b11},
        {1'b1,1'b0,1'b1,8'hE6,8'h66,2'b11},
        {1'b1,1'b0,1'b0,8'h77,8'hE7,2'b11},
        {1'b1,1'b0,1'b1,8'hE8,8'h88,2'b11},
        {1'b1,1'b0,1'b0,8'h99,8'hE9,2'b11},
        {1'b1,1'b0,1'b1,8'hEA,8'hAA,2'b10},
        {1'b1,1'b0,1'b0,8'hBB,8'hEB,2'b10},
        {1'b1,1'b1,1'b1,8'hEC,8'hCC,2'b10},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b01},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b01},
        {1'b1,1'b1,1'b1,8'hED,8'hDD,2'b11},
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b01}
    };

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_word(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Compare outputs with the model (called away from the clock edge).
    task automatic check_model(string tag);
        check_bit({tag, " R2 pop_ok"}, pop_ok, mc != 0);
        check_bit({tag, " R3 push_ok"}, push_ok, mc != D);
        if (mc != 0)
            check_word({tag, " R7 R8 dout"}, dout, mq[mh]);
    endtask

    // One clock cycle of stimulus; the model applies the acceptance rules.
    task automatic cyc(logic p, logic q, logic s, logic [W-1:0] a, logic [W-1:0] b, string tag);
        bit rd_ok, wr_ok, do_pop, do_push;
        push_req = p; pop_req = q; bus_sel = s; din_a = a; din_b = b;
        rd_ok   = (mc != 0);
        wr_ok   = (mc != D);
        do_pop  = q && rd_ok;
        do_push = p && (wr_ok || do_pop);
        if (do_pop) begin
            mh = (mh + 1) % D;
            mc--;
        end
        if (do_push) begin
            mq[mt] = s ? b : a;
            mt = (mt + 1) % D;
            mc++;
        end
        @(posedge clk);
        #1;
        check_model(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_bit("R1 pop_ok after reset", pop_ok, 1'b0);
        check_bit("R1 push_ok after reset", push_ok, 1'b1);

        // Table walk: R4 selection, R9 partial collision, R6 full push,
        // R10 full collision, R8 wrap, R5 empty pop, R11 empty collision.
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:10], VEC[i][9:2], "table");
            check_bit("R2 table pop_ok", pop_ok, VEC[i][1]);
            check_bit("R3 table push_ok", push_ok, VEC[i][0]);
        end

        // R4: each bus alone, head visible next cycle (R11 no fall-through)
        cyc(1'b1, 1'b0, 1'b1, 8'h5A, 8'hA5, "R4 sel1");
        check_word("R4 din_b stored", dout, 8'hA5);
        cyc(1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3, "R4 sel0");
        check_word("R4 head unchanged by second push", dout, 8'hA5);

        // R7: head holds over idle cycles
        held = dout;
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, "R7 idle");
        check_word("R7 held head", dout, held);

        // R6: fill to full, then push without pop changes nothing
        while (mc < D) cyc(1'b1, 1'b0, 1'b0, 8'(8'h40 + mc), 8'hEE, "fill");
        cyc(1'b1, 1'b0, 1'b1, 8'h01, 8'h02, "R6 push while full");
        check_word("R6 dout kept", dout, 8'hA5);

        // R1: reset with requests active clears everything
        rst = 1'b1;
        push_req = 1'b1; pop_req = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        push_req = 1'b0; pop_req = 1'b0;
        mh = 0; mt = 0; mc = 0;
        check_bit("R1 pop_ok after mid reset", pop_ok, 1'b0);
        check_bit("R1 push_ok after mid reset", push_ok, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R5 pop after reset");
        cyc(1'b1, 1'b0, 1'b0, 8'h77, 8'h88, "R4 after reset");
        check_word("R4 din_a stored", dout, 8'h77);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule